// File: doc/BRIEF.md
# Performance event counter bank

A bank of event counters for a processor's monitoring logic. Each of `NUM_CTR` counters has its own event code and privilege filter and advances by one in each cycle in which its selected event pulse is high and its filter allows the current privilege. Software reaches the bank through one flat register port. A counter's value and its event configuration are reached indirectly: software first writes an index to a selector, then uses a value window and a configuration window.

Counter enables and interrupt masks each have a write-one-to-set address and a write-one-to-clear address, so one counter's bit can change without a read-modify-write. A counter that wraps past its all-ones value latches a sticky overflow flag, which software clears by writing one to it. A single level interrupt stays high while any flagged counter is also unmasked. A control word carries the global run bit and read-only identification fields.

Register reads are combinational from `addr_i`. Writes take effect at the rising clock edge where `wr_en_i` is high.

Top module: `evt_ctr_bank`

## Requirements
- R1: After reset all counters, configurations, the selector, counter enables, interrupt masks, overflow flags and the global run bit read as zero, and `irq_o` is low.
- R2: A counter increments by one at a clock edge only when all of these hold: the global run bit (control address 0x0, bit 0) is 1, the counter's enable bit is 1, the event input bit chosen by its event code is 1, and its privilege filter allows the current mode. Otherwise it holds its value.
- R3: Configuration bit 31 blocks counting while `priv_i` is 0 (user mode), and bit 30 blocks counting while `priv_i` is 1 (privileged mode). With both bits clear the counter counts in both modes. Bits [3:0] hold the event code.
- R4: A counter at 0xFFFFFFFF that increments becomes 0 and sets its bit in the overflow flags (address 0x5). When a wrap and a clear of the same flag fall on one edge, the flag ends up set.
- R5: Writing to enable-set (0x1) turns on each counter whose data bit is 1. Writing to enable-clear (0x2) turns off each counter whose data bit is 1. Zero bits leave the enables unchanged, and writing all ones to 0x2 disables every counter. Both addresses read back the current enables.
- R6: Interrupt masks work the same way through mask-set (0x3) and mask-clear (0x4), and both addresses read back the current masks.
- R7: Writing to the overflow address (0x5) clears each flag whose data bit is 1 and leaves the others unchanged. A read returns the current flags.
- R8: The selector (0x6, low 8 bits, readable) picks a counter. The value window (0x7) reads and writes that counter, and the configuration window (0x8) reads and writes its configuration. With a selector not below `NUM_CTR`, both windows read 0 and writes to them change nothing.
- R9: The control word reads {implementer[31:24], part code[23:16], counter count[15:11], zero[10:1], run[0]}. Only bit 0 is writable.
- R10: `irq_o` is high exactly while some counter has both its overflow flag and its interrupt mask bit set.
- R11: A write to the value window on the same edge as a qualifying event loads the written value, and the event is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| evt_i | input | NUM_EVT | Per-cycle event pulses, one per event code |
| priv_i | input | 1 | Current mode: 1 privileged, 0 user |
| irq_o | output | 1 | Level overflow interrupt |

## Verification
The bench aims at these cases:
- Opposite privilege filters on two counters that share one event code. A swapped filter polarity would count in the wrong mode.
- A counter left disabled while its event pulses, and a global stop. A design that ignored either gate would drift.
- A wrap from 0xFFFFFFFE through 0xFFFFFFFF, checking the flag only after the second step. A design with an early or missing overflow would show up here.
- A same-edge wrap and flag clear, where a clear-priority design would drop the flag.
- A same-edge counter write and event, where an additive design would read 0x101 instead of 0x100.
- An out-of-range selector, to confirm that neither window reads an aliased counter or writes into one.

// File: rtl/evt_ctr_pkg.sv
package evt_ctr_pkg;
  localparam int ADDR_W = 4;
  localparam int IDX_W  = 8;

  localparam logic [ADDR_W-1:0] A_CTRL    = 4'h0;
  localparam logic [ADDR_W-1:0] A_CEN_SET = 4'h1;
  localparam logic [ADDR_W-1:0] A_CEN_CLR = 4'h2;
  localparam logic [ADDR_W-1:0] A_IEN_SET = 4'h3;
  localparam logic [ADDR_W-1:0] A_IEN_CLR = 4'h4;
  localparam logic [ADDR_W-1:0] A_OVF     = 4'h5;
  localparam logic [ADDR_W-1:0] A_SEL     = 4'h6;
  localparam logic [ADDR_W-1:0] A_DATA    = 4'h7;
  localparam logic [ADDR_W-1:0] A_TYPE    = 4'h8;

  localparam int CFG_NO_USER = 31;
  localparam int CFG_NO_PRIV = 30;
endpackage

// File: rtl/evt_ctr_w1sc.sv
module evt_ctr_w1sc #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_we_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q <= '0;
    else if (set_we_i) q <= q | wdata_i;
    else if (clr_we_i) q <= q & ~wdata_i;
  end

  assign q_o = q;
endmodule

// File: rtl/evt_ctr_slice.sv
module evt_ctr_slice
  import evt_ctr_pkg::*;
#(
  parameter int CTR_W   = 32,
  parameter int NUM_EVT = 16,
  parameter int CODE_W  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               priv_i,
  input  logic               cfg_we_i,
  input  logic [31:0]        cfg_wdata_i,
  input  logic               cnt_we_i,
  input  logic [CTR_W-1:0]   cnt_wdata_i,
  output logic [CTR_W-1:0]   cnt_o,
  output logic [31:0]        cfg_o,
  output logic               wrap_o
);
  localparam int EVT_SPAN = 1 << CODE_W;

  logic [CODE_W-1:0]   code_q;
  logic                no_user_q, no_priv_q;
  logic [CTR_W-1:0]    cnt_q;
  logic [EVT_SPAN-1:0] evt_pad;
  logic                hit, allow, inc;
  logic                unused_cfg;

  assign unused_cfg = ^cfg_wdata_i[29:CODE_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q    <= '0;
      no_user_q <= 1'b0;
      no_priv_q <= 1'b0;
    end else if (cfg_we_i) begin
      code_q    <= cfg_wdata_i[CODE_W-1:0];
      no_user_q <= cfg_wdata_i[CFG_NO_USER];
      no_priv_q <= cfg_wdata_i[CFG_NO_PRIV];
    end
  end

  // unused codes above NUM_EVT see a constant zero
  assign evt_pad = EVT_SPAN'(evt_i);
  assign hit     = evt_pad[code_q];
  assign allow   = priv_i ? !no_priv_q : !no_user_q;
  assign inc     = run_i & hit & allow;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (cnt_we_i) cnt_q <= cnt_wdata_i;
    else if (inc)      cnt_q <= cnt_q + 1'b1;
  end

  assign wrap_o = inc & ~cnt_we_i & (&cnt_q);
  assign cnt_o  = cnt_q;

  always_comb begin
    cfg_o                = '0;
    cfg_o[CODE_W-1:0]    = code_q;
    cfg_o[CFG_NO_USER]   = no_user_q;
    cfg_o[CFG_NO_PRIV]   = no_priv_q;
  end
endmodule

// File: rtl/evt_ctr_bank.sv
module evt_ctr_bank
  import evt_ctr_pkg::*;
#(
  parameter int         NUM_CTR = 4,
  parameter int         CTR_W   = 32,
  parameter int         NUM_EVT = 16,
  parameter logic [7:0] IMPL_ID = 8'h5A,
  parameter logic [7:0] PART_ID = 8'h3C
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [3:0]         addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               priv_i,
  output logic               irq_o
);
  localparam int CODE_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

  logic [NUM_CTR-1:0]       cen_q, ien_q, ovf_q, wrap_vec, cnt_we, cfg_we, ovf_clr;
  logic [CTR_W-1:0]         cnt_arr [NUM_CTR];
  logic [31:0]              cfg_arr [NUM_CTR];
  logic [NUM_CTR*CTR_W-1:0] cnt_flat;
  logic [IDX_W-1:0]         sel_q;
  logic                     ctrl_en_q;
  logic [CTR_W-1:0]         rd_cnt;
  logic [31:0]              rd_cfg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_en_q <= 1'b0;
      sel_q     <= '0;
    end else if (wr_en_i) begin
      if (addr_i == A_CTRL) ctrl_en_q <= wdata_i[0];
      if (addr_i == A_SEL)  sel_q     <= wdata_i[IDX_W-1:0];
    end
  end

  evt_ctr_w1sc #(.W(NUM_CTR)) u_cen (
    .clk_i, .rst_ni,
    .set_we_i (wr_en_i && addr_i == A_CEN_SET),
    .clr_we_i (wr_en_i && addr_i == A_CEN_CLR),
    .wdata_i  (wdata_i[NUM_CTR-1:0]),
    .q_o      (cen_q)
  );

  evt_ctr_w1sc #(.W(NUM_CTR)) u_ien (
    .clk_i, .rst_ni,
    .set_we_i (wr_en_i && addr_i == A_IEN_SET),
    .clr_we_i (wr_en_i && addr_i == A_IEN_CLR),
    .wdata_i  (wdata_i[NUM_CTR-1:0]),
    .q_o      (ien_q)
  );

  assign ovf_clr = (wr_en_i && addr_i == A_OVF) ? wdata_i[NUM_CTR-1:0] : '0;

  // a new wrap beats a same-edge clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= '0;
    else         ovf_q <= (ovf_q & ~ovf_clr) | wrap_vec;
  end

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    assign cnt_we[i] = wr_en_i && addr_i == A_DATA && sel_q == IDX_W'(i);
    assign cfg_we[i] = wr_en_i && addr_i == A_TYPE && sel_q == IDX_W'(i);

    evt_ctr_slice #(.CTR_W(CTR_W), .NUM_EVT(NUM_EVT), .CODE_W(CODE_W)) u_slice (
      .clk_i, .rst_ni,
      .run_i       (ctrl_en_q & cen_q[i]),
      .evt_i,
      .priv_i,
      .cfg_we_i    (cfg_we[i]),
      .cfg_wdata_i (wdata_i),
      .cnt_we_i    (cnt_we[i]),
      .cnt_wdata_i (wdata_i[CTR_W-1:0]),
      .cnt_o       (cnt_arr[i]),
      .cfg_o       (cfg_arr[i]),
      .wrap_o      (wrap_vec[i])
    );

    assign cnt_flat[i*CTR_W +: CTR_W] = cnt_arr[i];
  end

  always_comb begin
    rd_cnt = '0;
    rd_cfg = '0;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (sel_q == IDX_W'(i)) begin
        rd_cnt = cnt_arr[i];
        rd_cfg = cfg_arr[i];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:               rdata_o = {IMPL_ID, PART_ID, 5'(NUM_CTR), 10'd0, ctrl_en_q};
      A_CEN_SET, A_CEN_CLR: rdata_o = 32'(cen_q);
      A_IEN_SET, A_IEN_CLR: rdata_o = 32'(ien_q);
      A_OVF:                rdata_o = 32'(ovf_q);
      A_SEL:                rdata_o = 32'(sel_q);
      A_DATA:               rdata_o = 32'(rd_cnt);
      A_TYPE:               rdata_o = rd_cfg;
      default:              rdata_o = '0;
    endcase
  end

  assign irq_o = |(ovf_q & ien_q);
endmodule

// File: rtl/evt_ctr_bank_chk.sv
module evt_ctr_bank_chk
  import evt_ctr_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int CTR_W   = 32
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     wr_en_i,
  input logic [3:0]               addr_i,
  input logic [31:0]              wdata_i,
  input logic                     irq_o,
  input logic [NUM_CTR-1:0]       cen_q,
  input logic [NUM_CTR-1:0]       ien_q,
  input logic [NUM_CTR-1:0]       ovf_q,
  input logic [NUM_CTR-1:0]       wrap_vec,
  input logic                     ctrl_en_q,
  input logic [NUM_CTR*CTR_W-1:0] cnt_flat
);
  a_r5_cen_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_CEN_SET) |=>
      ((cen_q & $past(wdata_i[NUM_CTR-1:0])) == $past(wdata_i[NUM_CTR-1:0])));

  a_r5_cen_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_CEN_CLR) |=> ((cen_q & $past(wdata_i[NUM_CTR-1:0])) == '0));

  a_r6_ien_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_IEN_CLR) |=> ((ien_q & $past(wdata_i[NUM_CTR-1:0])) == '0));

  a_r2_global_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_en_q && !(wr_en_i && addr_i == A_DATA)) |=> $stable(cnt_flat));

  a_r4_wrap_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_vec != '0) |=> ((ovf_q & $past(wrap_vec)) == $past(wrap_vec)));

  a_r7_ovf_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_OVF && wrap_vec == '0) |=>
      ((ovf_q & $past(wdata_i[NUM_CTR-1:0])) == '0));

  a_r10_irq_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ovf_q != '0 && ien_q != '0));
endmodule

bind evt_ctr_bank evt_ctr_bank_chk #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .irq_o(irq_o), .cen_q(cen_q), .ien_q(ien_q),
  .ovf_q(ovf_q), .wrap_vec(wrap_vec), .ctrl_en_q(ctrl_en_q), .cnt_flat(cnt_flat)
);

// File: tb/evt_ctr_bank_bench.sv
`timescale 1ns/1ps
module evt_ctr_bank_bench;
  localparam logic [3:0] A_CTRL = 4'h0, A_CEN_SET = 4'h1, A_CEN_CLR = 4'h2,
                         A_IEN_SET = 4'h3, A_IEN_CLR = 4'h4, A_OVF = 4'h5,
                         A_SEL = 4'h6, A_DATA = 4'h7, A_TYPE = 4'h8;

  typedef struct {
    bit          is_irq;
    logic [3:0]  addr;
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] evt = '0;
  logic        priv = 1'b0;
  logic        irq;

  sb_item_t sb_q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  evt_ctr_bank u_evt_ctr_bank (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .priv_i(priv), .irq_o(irq)
  );

  // monitor: compares outputs against queued expectations
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (sb_q.size() > 0) begin
        sb_item_t it;
        logic [31:0] act;
        it  = sb_q.pop_front();
        act = it.is_irq ? {31'd0, irq} : rdata;
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s addr=%0h actual=%08h expected=%08h", it.tag, it.addr, act, it.exp);
        end
      end
    end
  end

  task automatic chk(input logic [3:0] a, input logic [31:0] e, input string tag);
    sb_item_t it;
    @(negedge clk);
    wr_en = 1'b0;
    addr  = a;
    it.is_irq = 1'b0; it.addr = a; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    sb_item_t it;
    @(negedge clk);
    it.is_irq = 1'b1; it.addr = addr; it.exp = {31'd0, e}; it.tag = tag;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [15:0] ev = '0);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; evt = ev;
    @(negedge clk);
    wr_en = 1'b0; evt = '0;
  endtask

  task automatic pulse(input logic [15:0] ev, input int n);
    @(negedge clk);
    evt = ev;
    repeat (n) @(negedge clk);
    evt = '0;
  endtask

  task automatic chk_ctr(input int i, input logic [31:0] e, input string tag);
    wr(A_SEL, 32'(i));
    chk(A_DATA, e, tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R9 control layout
    chk(A_CTRL, 32'h5A3C_2000, "R1/R9 ctrl after reset");
    chk(A_CEN_SET, 32'h0, "R1 enables zero");
    chk(A_IEN_SET, 32'h0, "R1 masks zero");
    chk(A_OVF, 32'h0, "R1 flags zero");
    chk(A_SEL, 32'h0, "R1 selector zero");
    chk(A_DATA, 32'h0, "R1 counter0 zero");
    chk(A_TYPE, 32'h0, "R1 config0 zero");
    chk_irq(1'b0, "R1 irq low");

    wr(A_CTRL, 32'hFFFF_FFFF);
    chk(A_CTRL, 32'h5A3C_2001, "R9 only run bit writable");

    // configurations: c0 code3, c1 code5 no-user, c2 code5 no-priv, c3 code7
    wr(A_SEL, 0); wr(A_TYPE, 32'h0000_0003);
    wr(A_SEL, 1); wr(A_TYPE, 32'h8000_0005);
    chk(A_TYPE, 32'h8000_0005, "R8 config window readback");
    wr(A_SEL, 2); wr(A_TYPE, 32'h4000_0005);
    wr(A_SEL, 3); wr(A_TYPE, 32'h0000_0007);
    wr(A_CEN_SET, 32'h7);
    chk(A_CEN_CLR, 32'h7, "R5 enable set");

    // R2 R3 filtered counting
    priv = 1'b0;
    pulse(16'h0028, 3);
    priv = 1'b1;
    pulse(16'h0020, 2);
    pulse(16'h0080, 4);
    priv = 1'b0;
    chk_ctr(0, 32'd3, "R2 counter0 counts its event");
    chk_ctr(1, 32'd2, "R3 no-user counts only privileged");
    chk_ctr(2, 32'd3, "R3 no-priv counts only user");
    chk_ctr(3, 32'd0, "R2 disabled counter holds");

    // R2 global stop
    wr(A_CTRL, 32'h0);
    pulse(16'h0008, 3);
    chk_ctr(0, 32'd3, "R2 global run off holds");
    wr(A_CTRL, 32'h1);

    // R5 zero bits and single clear
    wr(A_CEN_CLR, 32'h0);
    chk(A_CEN_SET, 32'h7, "R5 zero write no effect");
    wr(A_CEN_CLR, 32'h1);
    chk(A_CEN_SET, 32'h6, "R5 clear one bit");
    pulse(16'h0008, 2);
    chk_ctr(0, 32'd3, "R5 cleared counter holds");

    // R4 wrap
    wr(A_SEL, 0);
    wr(A_DATA, 32'hFFFF_FFFE);
    wr(A_CEN_SET, 32'h1);
    pulse(16'h0008, 1);
    chk(A_DATA, 32'hFFFF_FFFF, "R4 at max before wrap");
    chk(A_OVF, 32'h0, "R4 no early flag");
    pulse(16'h0008, 1);
    chk(A_DATA, 32'h0, "R4 wrap to zero");
    chk(A_OVF, 32'h1, "R4 flag on wrap");
    chk_irq(1'b0, "R10 masked flag no irq");

    // R6 R10 R7
    wr(A_IEN_SET, 32'h1);
    chk(A_IEN_CLR, 32'h1, "R6 mask set");
    chk_irq(1'b1, "R10 irq high");
    wr(A_IEN_CLR, 32'h0);
    chk_irq(1'b1, "R6 zero clear no effect");
    wr(A_OVF, 32'h0);
    chk(A_OVF, 32'h1, "R7 zero write keeps flag");
    wr(A_OVF, 32'h1);
    chk(A_OVF, 32'h0, "R7 write one clears");
    chk_irq(1'b0, "R10 irq drops");

    // R4 set wins over same-edge clear
    wr(A_DATA, 32'hFFFF_FFFF);
    pulse(16'h0008, 1);
    wr(A_DATA, 32'hFFFF_FFFF);
    wr(A_OVF, 32'h1, 16'h0008);
    chk(A_OVF, 32'h1, "R4 wrap beats clear");
    chk_irq(1'b1, "R10 irq after new wrap");

    // R11 write beats event
    wr(A_DATA, 32'h0000_0100, 16'h0008);
    chk(A_DATA, 32'h0000_0100, "R11 write wins over event");

    // R8 out of range
    wr(A_SEL, 4);
    chk(A_SEL, 32'h4, "R8 selector readback");
    wr(A_DATA, 32'h55);
    wr(A_TYPE, 32'h3);
    chk(A_DATA, 32'h0, "R8 out of range data reads zero");
    chk(A_TYPE, 32'h0, "R8 out of range config reads zero");
    chk_ctr(0, 32'h100, "R8 counter0 untouched");
    chk_ctr(1, 32'd2, "R8 counter1 untouched");
    chk_ctr(2, 32'd3, "R8 counter2 untouched");
    chk_ctr(3, 32'd0, "R8 counter3 untouched");

    // R5 R6 all ones clear
    wr(A_IEN_SET, 32'hF);
    wr(A_CEN_CLR, 32'hFFFF_FFFF);
    chk(A_CEN_SET, 32'h0, "R5 all ones clears all");
    wr(A_IEN_CLR, 32'hFFFF_FFFF);
    chk(A_IEN_SET, 32'h0, "R6 all ones clears all");
    chk_irq(1'b0, "R10 irq low when unmasked");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule